// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block inspects the destination address at the head of each received Ethernet frame and decides whether the frame is kept. The six address bytes arrive one per clock on a byte lane with a valid qualifier, the first byte marked by a start-of-frame strobe. While they stream in, a CRC over the address is accumulated. Group addresses are looked up in a 512-entry single-bit hash table indexed by that CRC. Individual addresses are compared with a programmed station address.

A small register write port programs the block. It loads the station address, sets or clears single hash table entries, and sets the receive enable and promiscuous bits. One decision, a valid pulse with an accept flag, is produced per frame. Payload, frame check and counters are handled elsewhere.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash index is computed from a CRC register seeded with 0xFFFFFFFF. Each address byte is folded in least significant bit first, in arrival order, with the reflected polynomial 0xEDB88320 and no final inversion. The index is the 32-bit result bit-reversed, bits 31 down to 23, so index bit 8 is CRC bit 0. A group address is accepted when its table entry is set and rejected when it is clear.
- R2: A write with regSel = 3 addresses the hash table. Bits 8:0 of regData hold the entry index and bit 9 the new value (1 sets, 0 clears). Only that one entry changes.
- R3: A group address is one whose first byte has bit 0 set. An individual address never consults the hash table, so a set entry at its index does not accept it.
- R4: An individual address is accepted when it equals the station address. regSel = 1 writes address bytes 0..3, with byte 0 in bits 7:0 and byte 3 in bits 31:24. regSel = 2 writes byte 4 in bits 7:0 and byte 5 in bits 15:8.
- R5: The all-ones broadcast address is accepted whenever receive is enabled, whatever the table holds.
- R6: regSel = 0 writes the control bits, bit 1 being promiscuous. With promiscuous and receive both enabled, every frame is accepted.
- R7: Control bit 0 is receive enable. While it is clear, every decision rejects, promiscuous or not.
- R8: decValid is a single-cycle pulse in the cycle after the sixth address byte is sampled. decAccept is high only together with decValid.
- R9: A start-of-frame strobe before the sixth byte discards the partial address. Only the restarted frame produces a decision.
- R10: Synchronous reset clears the hash table, the station address, and the enable and promiscuous bits, and holds decValid low.
- R11: A register write in the same cycle as the sixth address byte does not affect that frame's decision. It applies to later frames only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Address byte present on byteIn |
| sofIn | input | 1 | Marks the first address byte of a frame (with inValid) |
| byteIn | input | 8 | Address byte, wire order |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | 0 control, 1 station low, 2 station high, 3 table control |
| regData | input | 32 | Register write data |
| decValid | output | 1 | Decision pulse |
| decAccept | output | 1 | Frame accepted (valid with decValid) |

## Verification
Every decision is due in exactly one cycle: the clock edge that samples the sixth byte registers it, so it is visible during the following cycle. When the driver presents that byte, it records in its scoreboard entry the cycle count at which the pulse must appear. The monitor samples on the falling edge and fails any pulse that arrives in another cycle or with no entry pending. A same-cycle register write and an aborted partial address are driven on exact cycles, so their effects land on a known decision.

// File: rtl/filter_pkg.sv
package filter_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_STA_LO = 2'd1,
    SEL_STA_HI = 2'd2,
    SEL_TABLE  = 2'd3
  } reg_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic first;  // byte 0 of a frame is on the lane
    logic take;   // consume the byte on the lane
    logic last;   // sixth byte: produce a decision
  } step_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c, input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-8){1'b0}}, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/filter_ctrl.sv
module filter_ctrl
  import filter_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  input  logic  sofIn,
  output step_t step
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    step.first = inValid && sofIn;
    step.take  = inValid && (sofIn || active);
    step.last  = inValid && !sofIn && active && (cnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (step.first) begin
      active <= 1'b1;
      cnt    <= CNT_W'(1);
    end else if (step.last) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (step.take) begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/filter_dp.sv
module filter_dp
  import filter_pkg::*;
#(
  parameter int HASH_BITS = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  step_t       step,
  input  logic [7:0]  byteIn,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [31:0] regData,
  output logic        decValid,
  output logic        decAccept
);
  localparam int TABLE_N = 1 << HASH_BITS;
  localparam int HOLD_W = ADDR_W - 8;

  logic [TABLE_N-1:0]   hashTab;
  logic [CRC_W-1:0]     crcReg;
  logic [HOLD_W-1:0]    addrReg;
  logic [31:0]          stationLo;
  logic [15:0]          stationHi;
  logic                 rxEn;
  logic                 promisc;

  logic [CRC_W-1:0]     crcCur;
  logic [CRC_W-1:0]     crcNext;
  logic [HASH_BITS-1:0] hashIdx;
  logic [ADDR_W-1:0]    fullAddr;
  logic                 acceptNow;

  assign crcCur   = step.first ? CRC_SEED : crcReg;
  assign crcNext  = crcByte(crcCur, byteIn);
  assign fullAddr = {byteIn, addrReg};

  // index = bit-reversed CRC, top HASH_BITS bits
  for (genvar k = 0; k < HASH_BITS; k++) begin : g_rev
    assign hashIdx[k] = crcNext[HASH_BITS-1-k];
  end

  always_comb begin
    logic isGroup, isBcast, staHit;
    isGroup   = fullAddr[0];
    isBcast   = &fullAddr;
    staHit    = (fullAddr == {stationHi, stationLo});
    acceptNow = rxEn && (promisc || isBcast || (isGroup ? hashTab[hashIdx] : staHit));
  end

  always_ff @(posedge clk) begin
    if (step.take) begin
      crcReg  <= crcNext;
      addrReg <= {byteIn, addrReg[HOLD_W-1:8]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hashTab   <= '0;
      stationLo <= '0;
      stationHi <= '0;
      rxEn      <= 1'b0;
      promisc   <= 1'b0;
    end else if (regWe) begin
      unique case (reg_sel_e'(regSel))
        SEL_CTRL: begin
          rxEn    <= regData[0];
          promisc <= regData[1];
        end
        SEL_STA_LO: stationLo <= regData;
        SEL_STA_HI: stationHi <= regData[15:0];
        SEL_TABLE:  hashTab[regData[HASH_BITS-1:0]] <= regData[HASH_BITS];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= step.last;
      decAccept <= step.last && acceptNow;
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import filter_pkg::*;
#(
  parameter int HASH_BITS = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        sofIn,
  input  logic [7:0]  byteIn,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [31:0] regData,
  output logic        decValid,
  output logic        decAccept
);
  step_t step;

  filter_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .sofIn   (sofIn),
    .step    (step)
  );

  filter_dp #(.HASH_BITS(HASH_BITS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .byteIn    (byteIn),
    .regWe     (regWe),
    .regSel    (regSel),
    .regData   (regData),
    .decValid  (decValid),
    .decAccept (decAccept)
  );
endmodule

// File: rtl/filter_chk.sv
module filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       sofIn,
  input logic       regWe,
  input logic [1:0] regSel,
  input logic [1:0] ctrlBits,
  input logic       decValid,
  input logic       decAccept
);
  logic enShadow;
  logic promShadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      enShadow   <= 1'b0;
      promShadow <= 1'b0;
    end else if (regWe && regSel == 2'd0) begin
      enShadow   <= ctrlBits[0];
      promShadow <= ctrlBits[1];
    end
  end

  AST_DECISION_PULSE: assert property (@(posedge clk) disable iff (rst)
    decValid |=> !decValid); // R8
  AST_DECISION_TIMING: assert property (@(posedge clk) disable iff (rst)
    decValid |-> ($past(inValid) && !$past(sofIn))); // R8
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    decAccept |-> decValid); // R8
  AST_DISABLED_REJECTS: assert property (@(posedge clk) disable iff (rst)
    (decValid && !$past(enShadow)) |-> !decAccept); // R7
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    (decValid && $past(enShadow) && $past(promShadow)) |-> decAccept); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !decValid); // R10
endmodule

bind mcast_hash_filter filter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .sofIn     (sofIn),
  .regWe     (regWe),
  .regSel    (regSel),
  .ctrlBits  (regData[1:0]),
  .decValid  (decValid),
  .decAccept (decAccept)
);

// File: tb/tb_mcast_hash_filter.sv
`timescale 1ns/1ps
module tb_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        sofIn = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regData = '0;
  logic        decValid;
  logic        decAccept;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct { logic acc; int due; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mcast_hash_filter dut (.*);

  // reference hash: bitwise LSB-first over the 48 address bits
  function automatic int refIdx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    int idx;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      fb = c[0] ^ a[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    idx = 0;
    for (int k = 0; k < 9; k++) idx = (idx << 1) | int'(c[k]);
    return idx;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    regWe = 1'b1; regSel = sel; regData = data;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic tableWrite(input int idx, input bit val);
    regWrite(2'd3, {22'd0, val, 9'(idx)});
  endtask

  task automatic sendAddrW(input logic [47:0] a, input bit exp, input string tag,
                           input bit doWr, input logic [1:0] wSel, input logic [31:0] wData);
    item_t it;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      inValid = 1'b1;
      sofIn   = (k == 0);
      byteIn  = a[8*k +: 8];
      if (k == 5) begin
        if (doWr) begin
          regWe = 1'b1; regSel = wSel; regData = wData;
        end
        it.acc = exp; it.due = cyc + 1; it.tag = tag;
        q.push_back(it);
      end
    end
    @(posedge clk); #1;
    inValid = 1'b0; sofIn = 1'b0; regWe = 1'b0;
  endtask

  task automatic sendAddr(input logic [47:0] a, input bit exp, input string tag);
    sendAddrW(a, exp, tag, 1'b0, 2'd0, 32'd0);
  endtask

  // monitor: scoreboard compare, away from the active edge
  always @(negedge clk) begin
    if (!rst && decValid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected decision", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(cyc == it.due, {"R8 timing ", it.tag}, cyc, it.due);
        check(decAccept == it.acc, it.tag, int'(decAccept), int'(it.acc));
      end
    end else if (!rst && decAccept) begin
      check(1'b0, "R8 accept without valid", 1, 0);
    end
  end

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC_A  = {8'h01, 8'h00, 8'h00, 8'h5e, 8'h00, 8'h01};
  localparam logic [47:0] MC_B  = {8'h33, 8'h22, 8'h11, 8'h00, 8'h80, 8'h13};
  localparam logic [47:0] UC_U  = {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h02};
  localparam logic [47:0] UC_V  = {8'h67, 8'h55, 8'h44, 8'h33, 8'h22, 8'h02};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int idxA, idxB, idxU;
    idxA = refIdx(MC_A);
    idxB = refIdx(MC_B);
    idxU = refIdx(UC_U);

    repeat (3) @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(decValid == 1'b0, "R10 reset state decValid", int'(decValid), 0);

    // receive disabled after reset
    sendAddr(BCAST, 1'b0, "R7 disabled broadcast");
    regWrite(2'd0, 32'h1);
    sendAddr(BCAST, 1'b1, "R5 broadcast empty table");

    // hash lookup
    sendAddr(MC_A, 1'b0, "R1 group entry clear");
    tableWrite(idxA, 1'b1);
    sendAddr(MC_A, 1'b1, "R1 group entry set");
    sendAddr(MC_B, idxB == idxA, "R1 other group index");

    // single-entry writes
    tableWrite(idxA ^ 1, 1'b1);
    sendAddr(MC_A, 1'b1, "R2 neighbour set keeps entry");
    tableWrite(idxA, 1'b0);
    sendAddr(MC_A, (idxA ^ 1) == idxA, "R2 entry cleared");

    // individual address ignores table
    tableWrite(idxU, 1'b1);
    sendAddr(UC_U, 1'b0, "R3 individual ignores hash");

    // station address
    regWrite(2'd1, UC_U[31:0]);
    regWrite(2'd2, {16'd0, UC_U[47:32]});
    tableWrite(idxU, 1'b0);
    sendAddr(UC_U, 1'b1, "R4 station match");
    sendAddr(UC_V, 1'b0, "R4 station byte5 differs");

    // write in decision cycle
    sendAddrW(MC_A, 1'b0, "R11 same-cycle write", 1'b1, 2'd3, {22'd0, 1'b1, 9'(idxA)});
    sendAddr(MC_A, 1'b1, "R11 write applies later");

    // abandoned partial address
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      inValid = 1'b1; sofIn = (k == 0); byteIn = MC_B[8*k +: 8];
    end
    sendAddr(MC_A, 1'b1, "R9 restart after partial");

    // promiscuous
    regWrite(2'd0, 32'h3);
    sendAddr(UC_V, 1'b1, "R6 promiscuous unicast");
    sendAddr(MC_B, 1'b1, "R6 promiscuous group");

    // promiscuous but disabled
    regWrite(2'd0, 32'h2);
    sendAddr(BCAST, 1'b0, "R7 disabled promiscuous broadcast");
    sendAddr(UC_U, 1'b0, "R7 disabled station match");

    // reset clears state
    regWrite(2'd0, 32'h3);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(decValid == 1'b0, "R10 decValid in reset", int'(decValid), 0);
    #1 rst = 1'b0;
    regWrite(2'd0, 32'h1);
    sendAddr(MC_A, 1'b0, "R10 table cleared");
    sendAddr(UC_U, 1'b0, "R10 station cleared");
    sendAddr(BCAST, 1'b1, "R5 broadcast after reset");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, "R8 pending decisions", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule